// File: doc/BRIEF.md
# Right-Justified Multi-Width Serial Audio Receiver

This block receives two channels of PCM audio from an external interpolation filter over four wires: a word clock, a bit clock and one serial data line per channel. All four wires are resynchronised into the system clock domain. Every data bit is shifted into a per-channel register on a bit-clock rising edge. A falling word-clock edge closes a sample period. The samples are right-justified and sent MSB first, so the sample bits are the last N bits received before that falling edge. N is 16, 24 or 32, and a 3-bit format code selects it. The extracted sample is sign-extended to 32 bits. Both channels are presented together with a one-cycle valid strobe.

A small configuration port writes the format code and a 2-bit operating-speed code in one strobe. The speed code is decoded into an oversampling ratio of 4, 8 or 16. Illegal codes are flagged. An illegal format code suppresses sample delivery and freezes the outputs. A reserved speed code leaves the previously decoded ratio in place.

Top module: `rj_audio_rx`

## Requirements
- R1: Format code 3'b000 selects 16-bit samples. Only the last 16 bits before the boundary are used, and bit 15 is copied into bits 31..16.
- R2: Format code 3'b001 selects 32-bit samples. The last 32 bits before the boundary are delivered unchanged.
- R3: Format code 3'b010 selects 24-bit samples, with bit 23 copied into bits 31..24. This is the format in effect after reset.
- R4: Any other format code raises `fmt_err_o`. While it is in effect, a boundary produces no valid strobe and `left_o`/`right_o` keep their last values.
- R5: Data bits are taken on bit-clock rising edges, and a word-clock falling edge is the sample boundary. `valid_o` rises on the third system-clock rising edge after the word clock falls. It is high for exactly one cycle, and both channels update in that same cycle.
- R6: Speed code 2'b00 gives `ratio_o` = 8, 2'b01 gives 4 and 2'b10 gives 16. After reset the ratio is 8.
- R7: Speed code 2'b11 is reserved. Writing it sets `speed_err_o` and leaves `ratio_o` unchanged. The next write of a legal speed code clears `speed_err_o`.
- R8: A configuration write is applied on the clock edge that samples `cfg_we`. A boundary processed on that same edge uses the format that was in effect before the write.
- R9: After reset, `left_o` and `right_o` are zero, and `valid_o`, `fmt_err_o` and `speed_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdck_i | input | 1 | Word clock; falling edge ends a sample period |
| bck_i | input | 1 | Bit clock; data taken on rising edge |
| dat_l_i | input | 1 | Left-channel serial data |
| dat_r_i | input | 1 | Right-channel serial data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fmt | input | 3 | Format code written on `cfg_we` |
| cfg_speed | input | 2 | Speed code written on `cfg_we` |
| left_o | output | 32 | Sign-extended left sample |
| right_o | output | 32 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe: new samples present |
| fmt_err_o | output | 1 | Current format code is illegal |
| speed_err_o | output | 1 | Last speed write used the reserved code |
| ratio_o | output | 5 | Decoded oversampling ratio (4, 8 or 16) |

## Verification
A configuration write and a sample boundary can land on the same system-clock edge, and the question is then which format extracts the sample. The bench drops the word clock and then asserts a format change exactly two falling clock edges later, so the write strobe is sampled on the edge that registers the boundary. The scoreboard expects that word decoded with the old width and the following word with the new width. Upper bits of every word carry junk, so decoding with the wrong width shows up at once.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;

    localparam int OUT_W   = 32;
    localparam int RATIO_W = 5;

    localparam logic [2:0] FMT_16 = 3'b000;
    localparam logic [2:0] FMT_32 = 3'b001;
    localparam logic [2:0] FMT_24 = 3'b010;

    localparam logic [1:0] SPD_X8  = 2'b00;
    localparam logic [1:0] SPD_X4  = 2'b01;
    localparam logic [1:0] SPD_X16 = 2'b10;
    localparam logic [1:0] SPD_RSV = 2'b11;

    function automatic logic fmt_legal(input logic [2:0] code);
        return (code == FMT_16) || (code == FMT_32) || (code == FMT_24);
    endfunction

    // Keep the low N bits (N from the format code) and extend their sign.
    function automatic logic [OUT_W-1:0] take_tail(input logic [OUT_W-1:0] raw,
                                                   input logic [2:0] code);
        logic [OUT_W-1:0] r;
        case (code)
            FMT_16:  r = {{(OUT_W-16){raw[15]}}, raw[15:0]};
            FMT_24:  r = {{(OUT_W-24){raw[23]}}, raw[23:0]};
            default: r = raw;
        endcase
        return r;
    endfunction

    function automatic logic [RATIO_W-1:0] spd_ratio(input logic [1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            SPD_X4:  r = RATIO_W'(4);
            SPD_X16: r = RATIO_W'(16);
            default: r = RATIO_W'(8);
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic [2:0]         fmt;
        logic [RATIO_W-1:0] ratio;
        logic               spd_err;
    } cfg_state_t;

endpackage

// File: rtl/rjrx_sync.sv
module rjrx_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rjrx_shift.sv
module rjrx_shift #(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_i,
    output logic [DEPTH-1:0] word_o
);
    logic [DEPTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (shift_en) sr_d = {sr_q[DEPTH-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word_o = sr_q;
endmodule

// File: rtl/rjrx_cfg.sv
module rjrx_cfg
    import rjrx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [2:0]         fmt_wr,
    input  logic [1:0]         spd_wr,
    output logic [2:0]         fmt_o,
    output logic               fmt_ok_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               spd_err_o
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.fmt = fmt_wr;
            if (spd_wr == SPD_RSV) begin
                st_d.spd_err = 1'b1;
            end else begin
                st_d.spd_err = 1'b0;
                st_d.ratio   = spd_ratio(spd_wr);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fmt     <= FMT_24;
            st_q.ratio   <= spd_ratio(SPD_X8);
            st_q.spd_err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fmt_o     = st_q.fmt;
    assign fmt_ok_o  = fmt_legal(st_q.fmt);
    assign ratio_o   = st_q.ratio;
    assign spd_err_o = st_q.spd_err;
endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
    import rjrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdck_i,
    input  logic               bck_i,
    input  logic               dat_l_i,
    input  logic               dat_r_i,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_fmt,
    input  logic [1:0]         cfg_speed,
    output logic [OUT_W-1:0]   left_o,
    output logic [OUT_W-1:0]   right_o,
    output logic               valid_o,
    output logic               fmt_err_o,
    output logic               speed_err_o,
    output logic [RATIO_W-1:0] ratio_o
);
    localparam int NCH    = 2;
    localparam int IDX_WD = 0;
    localparam int IDX_BK = 1;
    localparam int IDX_D0 = 2;

    typedef struct packed {
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
        logic             valid;
        logic             wd_prev;
        logic             bk_prev;
    } top_state_t;

    logic [IDX_D0+NCH-1:0] raw_in, syn;
    logic [NCH-1:0][OUT_W-1:0] words;
    logic [2:0] fmt_cur;
    logic       fmt_ok;
    logic       bk_rise, wd_fall;
    top_state_t st_d, st_q;

    assign raw_in = {dat_r_i, dat_l_i, bck_i, wdck_i};

    rjrx_sync #(.W(IDX_D0+NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(syn)
    );

    assign bk_rise = syn[IDX_BK] & ~st_q.bk_prev;
    assign wd_fall = ~syn[IDX_WD] & st_q.wd_prev;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rjrx_shift #(.DEPTH(OUT_W)) u_shift (
            .clk(clk), .rst_n(rst_n), .shift_en(bk_rise),
            .bit_i(syn[IDX_D0+c]), .word_o(words[c])
        );
    end

    rjrx_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .fmt_wr(cfg_fmt),
        .spd_wr(cfg_speed), .fmt_o(fmt_cur), .fmt_ok_o(fmt_ok),
        .ratio_o(ratio_o), .spd_err_o(speed_err_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.wd_prev = syn[IDX_WD];
        st_d.bk_prev = syn[IDX_BK];
        if (wd_fall && fmt_ok) begin
            st_d.left  = take_tail(words[0], fmt_cur);
            st_d.right = take_tail(words[1], fmt_cur);
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o    = st_q.left;
    assign right_o   = st_q.right;
    assign valid_o   = st_q.valid;
    assign fmt_err_o = ~fmt_ok;
endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_speed,
    input logic [31:0] left_o,
    input logic [31:0] right_o,
    input logic        valid_o,
    input logic        fmt_err_o,
    input logic        speed_err_o,
    input logic [4:0]  ratio_o
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r4_hold_on_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err_o |=> (!valid_o && $stable(left_o) && $stable(right_o)));

    a_r7_reserved_keeps_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_speed == 2'b11) |=> ($stable(ratio_o) && speed_err_o));

    a_r6_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ratio_o) == 1) && (ratio_o[4] || ratio_o[3] || ratio_o[2]));

    a_r7_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_speed != 2'b11) |=> !speed_err_o);
endmodule

bind rj_audio_rx rj_audio_rx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_speed(cfg_speed),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .fmt_err_o(fmt_err_o), .speed_err_o(speed_err_o), .ratio_o(ratio_o)
);

// File: tb/rj_audio_rx_tb_top.sv
module rj_audio_rx_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdck = 1'b0, bck = 1'b0, dl = 1'b0, dr = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_fmt = 3'b010;
    logic [1:0] cfg_speed = 2'b00;
    logic [31:0] left_o, right_o;
    logic valid_o, fmt_err_o, speed_err_o;
    logic [4:0] ratio_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [63:0] exp_q[$];
    logic [31:0] last_l = '0, last_r = '0;
    logic [2:0]  fmt_m  = 3'b010;

    always #(CLK_PERIOD/2) clk = ~clk;

    rj_audio_rx dut_i (
        .clk(clk), .rst_n(rst_n), .wdck_i(wdck), .bck_i(bck),
        .dat_l_i(dl), .dat_r_i(dr), .cfg_we(cfg_we), .cfg_fmt(cfg_fmt),
        .cfg_speed(cfg_speed), .left_o(left_o), .right_o(right_o),
        .valid_o(valid_o), .fmt_err_o(fmt_err_o), .speed_err_o(speed_err_o),
        .ratio_o(ratio_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ext(input logic [31:0] raw, input logic [2:0] f);
        if (f == 3'b000) return {{16{raw[15]}}, raw[15:0]};
        if (f == 3'b010) return {{8{raw[23]}}, raw[23:0]};
        return raw;
    endfunction

    // Monitor: pops one expected pair per strobe.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check("R4/R5 unexpected strobe", {left_o, right_o}, 64'hx);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check("R1/R2/R3/R5 sample pair", {left_o, right_o}, e);
                last_l = e[63:32];
                last_r = e[31:0];
            end
        end
    end

    task automatic cfg_write(input logic [2:0] f, input logic [1:0] s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_fmt = f; cfg_speed = s;
        @(negedge clk);
        cfg_we = 1'b0;
        fmt_m = f;
    endtask

    // Send 32 bits per channel, MSB first; word clock high for the second half.
    task automatic send_word(input logic [31:0] l, input logic [31:0] r);
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            bck = 1'b0; dl = l[31-b]; dr = r[31-b]; wdck = (b >= 16);
            @(negedge clk);
            @(negedge clk);
            bck = 1'b1;
            @(negedge clk);
        end
    endtask

    // Drop the word clock; optionally write a new format on the boundary edge (R8).
    task automatic boundary(input logic [31:0] l, input logic [31:0] r,
                            input bit race, input logic [2:0] newf);
        if (fmt_m == 3'b000 || fmt_m == 3'b001 || fmt_m == 3'b010)
            exp_q.push_back({model_ext(l, fmt_m), model_ext(r, fmt_m)});
        @(negedge clk);
        bck = 1'b0; wdck = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (race) begin
            cfg_we = 1'b1; cfg_fmt = newf; cfg_speed = 2'b00;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        if (race) fmt_m = newf;
        repeat (6) @(negedge clk);
    endtask

    task automatic word(input logic [31:0] l, input logic [31:0] r);
        send_word(l, r);
        boundary(l, r, 1'b0, 3'b000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {left_o, right_o}, 64'h0);
        check("R9 reset flags", {61'h0, valid_o, fmt_err_o, speed_err_o}, 64'h0);
        check("R6 reset ratio", {59'h0, ratio_o}, 64'd8);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 default 24-bit, negative and positive, with junk in upper bits
        word(32'hA5801234, 32'h3C12ABCD);
        word(32'hFF7FFFFF, 32'h00800000);

        // R1 16-bit
        cfg_write(3'b000, 2'b00);
        word(32'h12348000, 32'hDEAD7FFF);
        word(32'hFFFF0001, 32'h0000FFFF);

        // R2 32-bit
        cfg_write(3'b001, 2'b00);
        word(32'h80000001, 32'h7FFFFFFE);

        // R4 illegal format: flag, no strobe, outputs held
        cfg_write(3'b101, 2'b00);
        @(negedge clk);
        check("R4 fmt_err set", {63'h0, fmt_err_o}, 64'h1);
        word(32'h11111111, 32'h22222222);
        check("R4 outputs held", {left_o, right_o}, {last_l, last_r});
        check("R4 queue drained", 64'(exp_q.size()), 64'h0);
        cfg_write(3'b010, 2'b00);
        @(negedge clk);
        check("R4 fmt_err cleared", {63'h0, fmt_err_o}, 64'h0);

        // R8 format write on the boundary edge: old (24) used, then new (16)
        send_word(32'hC0F00001, 32'h0F00F00F);
        boundary(32'hC0F00001, 32'h0F00F00F, 1'b1, 3'b000);
        word(32'h5555AAAA, 32'hAAAA5555);

        // R6 / R7 speed decoding
        cfg_write(fmt_m, 2'b01);
        @(negedge clk);
        check("R6 ratio x4", {59'h0, ratio_o}, 64'd4);
        cfg_write(fmt_m, 2'b10);
        @(negedge clk);
        check("R6 ratio x16", {59'h0, ratio_o}, 64'd16);
        cfg_write(fmt_m, 2'b11);
        @(negedge clk);
        check("R7 reserved keeps ratio", {59'h0, ratio_o}, 64'd16);
        check("R7 speed_err set", {63'h0, speed_err_o}, 64'h1);
        cfg_write(fmt_m, 2'b00);
        @(negedge clk);
        check("R7 speed_err cleared", {63'h0, speed_err_o}, 64'h0);
        check("R6 ratio x8", {59'h0, ratio_o}, 64'd8);

        repeat (10) @(negedge clk);
        check("R5 all expected strobes seen", 64'(exp_q.size()), 64'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule